// File: doc/BRIEF.md
# Four-Way Set-Associative Tag Lookup with Age-Based Replacement

This block is the tag-match and replacement-choice stage of a four-way set-associative cache. An address is split into a byte offset, a set index and a tag. The index selects one set. The tag is compared against all four ways of that set at the same time. When one way holds a valid copy of the tag, the block reports a hit, gives a one-hot vector naming that way, and passes that way's data word out through an AND-OR selector. Lookup results are combinational from the address and the stored state.

For every set the block keeps a two-bit age for each way. The four ages always form a permutation of 0 to 3, where age 0 is the most recently touched way. On a miss, the block offers a victim way. The victim is the lowest-numbered invalid way if the set has one; otherwise it is the way of age 3. A fill takes an address and a data word and writes them into the victim way of the fill address's set. If the tag is already present in that set, the fill overwrites that way instead. Hits and fills both make the touched way the youngest.

Top module: `sa4_lookup`

## Requirements
- R1: Address bits [OFFSET_W-1:0] are ignored. The next IDX_W bits select the set, and the remaining upper bits form the tag. With the defaults this is 16-bit addresses, 2 offset bits, 3 index bits (bits [4:2]) and 11 tag bits (bits [15:5]).
- R2: A hit occurs when `lk_valid` is 1 and a valid way of the indexed set holds the lookup tag. Then `hit`=1, bit w of `hit_way` is set for matching way w, and `hit_data` equals that way's stored data. In every other case `hit`, `hit_way` and `hit_data` are all 0.
- R3: At most one way of a set ever matches a tag, and `multi_hit` stays 0. A fill whose tag is already present in its set rewrites that same way.
- R4: `victim_way` is one-hot for the set indexed by `lk_addr`. It names the lowest-numbered invalid way (bit 0 = way 0) if any way is invalid. Otherwise it names the least recently touched way.
- R5: A lookup hit in a cycle without a fill makes the hit way the most recent. Every way that was more recent than it moves one step older, and older ways keep their order.
- R6: When `fill_valid` is 1, the chosen way of the fill set becomes valid at the next clock edge and holds the fill tag and `fill_data`. That way also becomes the most recent.
- R7: If a fill and a lookup occur in the same cycle, the lookup outputs reflect the state before the fill. Only the fill updates recency, so the lookup hit leaves no trace in the ages.
- R8: After reset every way is invalid and no lookup hits. The victim is way 0, and the initial recency order from youngest to oldest is way 0, 1, 2, 3.
- R9: A lookup that misses changes no stored state, so the victim of that set stays the same in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_addr | input | ADDR_W | Lookup address |
| fill_valid | input | 1 | Write a block into its set |
| fill_addr | input | ADDR_W | Address of the block being filled |
| fill_data | input | DATA_W | Data word of the block being filled |
| hit | output | 1 | Lookup matched a valid way |
| hit_way | output | 4 | One-hot matching way |
| hit_data | output | DATA_W | Data of the matching way |
| victim_way | output | 4 | One-hot replacement choice for the lookup set |
| multi_hit | output | 1 | More than one way matched (error) |

## Verification
The hardest state to reach is a full set with a scrambled recency order, followed by a miss that has to evict exactly the oldest way. A merely early-filled way is not enough. To get there, the random stimulus draws tags from a pool of five per set, so every set fills up and keeps conflicting. Random hits then reorder the ages before each eviction. Directed sequences cover two further cases: a fill and a lookup in the same cycle, and a refill of a tag that is already present.

// File: rtl/sa4_lookup.sv
module sa4_lookup #(
  parameter int ADDR_W   = 16,
  parameter int OFFSET_W = 2,
  parameter int SETS     = 8,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              hit,
  output logic [3:0]        hit_way,
  output logic [DATA_W-1:0] hit_data,
  output logic [3:0]        victim_way,
  output logic              multi_hit
);
  localparam int WAYS  = 4;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFFSET_W - IDX_W;

  logic [WAYS-1:0]   vld_q [SETS];
  logic [2*WAYS-1:0] age_q [SETS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [DATA_W-1:0] dat_q [SETS][WAYS];

  wire [IDX_W-1:0] lk_idx = lk_addr[OFFSET_W +: IDX_W];
  wire [TAG_W-1:0] lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] fl_idx = fill_addr[OFFSET_W +: IDX_W];
  wire [TAG_W-1:0] fl_tag = fill_addr[ADDR_W-1 -: TAG_W];

  function automatic logic [WAYS-1:0] pick(input logic [WAYS-1:0] v, input logic [2*WAYS-1:0] ag);
    pick = '0;
    if (!(&v)) begin
      for (int w = WAYS-1; w >= 0; w--) if (!v[w]) pick = WAYS'(1) << w;
    end else begin
      for (int w = 0; w < WAYS; w++) if (ag[2*w +: 2] == 2'd3) pick[w] = 1'b1;
    end
  endfunction

  function automatic logic [1:0] oh2idx(input logic [WAYS-1:0] oh);
    oh2idx = 2'd0;
    for (int w = 0; w < WAYS; w++) if (oh[w]) oh2idx = 2'(w);
  endfunction

  function automatic logic [2*WAYS-1:0] touch(input logic [2*WAYS-1:0] ag, input logic [1:0] w);
    logic [1:0] a;
    a = ag[2*int'(w) +: 2];
    touch = ag;
    for (int j = 0; j < WAYS; j++)
      if (ag[2*j +: 2] < a) touch[2*j +: 2] = ag[2*j +: 2] + 2'd1;
    touch[2*int'(w) +: 2] = 2'd0;
  endfunction

  logic [WAYS-1:0] lk_match, fl_match, fl_tgt;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_match[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
      fl_match[w] = vld_q[fl_idx][w] && (tag_q[fl_idx][w] == fl_tag);
    end
    fl_tgt = (|fl_match) ? fl_match : pick(vld_q[fl_idx], age_q[fl_idx]);
  end

  assign hit_way    = lk_valid ? lk_match : '0;
  assign hit        = |hit_way;
  assign multi_hit  = lk_valid && ($countones(lk_match) > 1);
  assign victim_way = pick(vld_q[lk_idx], age_q[lk_idx]);

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_way[w]) hit_data = hit_data | dat_q[lk_idx][w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        age_q[s] <= {2'd3, 2'd2, 2'd1, 2'd0};
      end
    end else if (fill_valid) begin
      vld_q[fl_idx] <= vld_q[fl_idx] | fl_tgt;
      age_q[fl_idx] <= touch(age_q[fl_idx], oh2idx(fl_tgt));
    end else if (hit) begin
      age_q[lk_idx] <= touch(age_q[lk_idx], oh2idx(hit_way));
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid) begin
      tag_q[fl_idx][oh2idx(fl_tgt)] <= fl_tag;
      dat_q[fl_idx][oh2idx(fl_tgt)] <= fill_data;
    end
  end

  logic [WAYS-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int w = 0; w < WAYS; w++) age_seen[age_q[lk_idx][2*w +: 2]] = 1'b1;
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_way)); // R2
  AST_NO_MULTI: assert property (@(posedge clk) disable iff (!rst_n) !multi_hit); // R3
  AST_VICTIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot(victim_way)); // R4
  AST_AGE_PERM: assert property (@(posedge clk) disable iff (!rst_n) &age_seen); // R5
  AST_FILL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) fill_valid |-> $onehot(fl_tgt)); // R6
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !hit && !fill_valid) |=> $stable(victim_way) || $changed(lk_addr)); // R9
endmodule

// File: tb/tb_sa4_lookup.sv
`timescale 1ns/1ps
module tb_sa4_lookup;
  localparam int AW = 16, DW = 16, SETS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, fill_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0, fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic hit, multi_hit;
  logic [3:0] hit_way, victim_way;
  logic [DW-1:0] hit_data;

  sa4_lookup dut (.clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .hit(hit), .hit_way(hit_way), .hit_data(hit_data), .victim_way(victim_way),
    .multi_hit(multi_hit));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit m_vld [SETS][4];
  logic [10:0] m_tag [SETS][4];
  logic [DW-1:0] m_dat [SETS][4];
  int m_age [SETS][4];

  task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tg, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input int tag, input int idx, input int off);
    return {11'(tag), 3'(idx), 2'(off)};
  endfunction

  function automatic logic [3:0] mvict(input int s);
    for (int w = 0; w < 4; w++) if (!m_vld[s][w]) return 4'(1 << w);
    for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) return 4'(1 << w);
    return 4'd0;
  endfunction

  task automatic mtouch(input int s, input int w);
    int a;
    a = m_age[s][w];
    for (int j = 0; j < 4; j++) if (m_age[s][j] < a) m_age[s][j]++;
    m_age[s][w] = 0;
  endtask

  function automatic int idx_of(input logic [3:0] oh);
    for (int w = 0; w < 4; w++) if (oh[w]) return w;
    return 0;
  endfunction

  task automatic cyc(input bit lkv, input logic [15:0] la, input bit fv,
                     input logic [15:0] fa, input logic [15:0] fd, input string tg);
    int s, fs;
    logic [3:0] ew, ev, ft;
    logic [DW-1:0] ed;
    @(negedge clk);
    lk_valid = lkv; lk_addr = la; fill_valid = fv; fill_addr = fa; fill_data = fd;
    #1;
    s = int'(la[4:2]);
    ew = '0; ed = '0;
    for (int w = 0; w < 4; w++)
      if (lkv && m_vld[s][w] && m_tag[s][w] == la[15:5]) begin ew[w] = 1'b1; ed = ed | m_dat[s][w]; end
    ev = mvict(s);
    chk(hit == (|ew), {tg, " hit (R2)"}, 32'(hit), 32'(|ew));
    chk(hit_way == ew, {tg, " hit_way (R2)"}, 32'(hit_way), 32'(ew));
    chk(hit_data == ed, {tg, " hit_data (R2)"}, 32'(hit_data), 32'(ed));
    chk(victim_way == ev, {tg, " victim (R4)"}, 32'(victim_way), 32'(ev));
    chk(multi_hit == 1'b0, {tg, " multi_hit (R3)"}, 32'(multi_hit), 32'd0);
    @(posedge clk);
    if (fv) begin
      fs = int'(fa[4:2]);
      ft = '0;
      for (int w = 0; w < 4; w++) if (m_vld[fs][w] && m_tag[fs][w] == fa[15:5]) ft[w] = 1'b1;
      if (ft == 0) ft = mvict(fs);
      m_vld[fs][idx_of(ft)] = 1'b1;
      m_tag[fs][idx_of(ft)] = fa[15:5];
      m_dat[fs][idx_of(ft)] = fd;
      mtouch(fs, idx_of(ft));
    end else if (lkv && (|ew)) begin
      mtouch(s, idx_of(ew));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 4; w++) begin m_vld[s][w] = 0; m_age[s][w] = w; m_tag[s][w] = '0; m_dat[s][w] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    cyc(1, mk(7, 2, 0), 0, 0, 0, "R8 reset lookup");
    // fill four tags into set 3: ways chosen in order 0..3
    for (int t = 0; t < 4; t++) cyc(0, mk(10 + t, 3, 0), 1, mk(10 + t, 3, 0), 16'h100 + 16'(t), "R6 fill set3");
    for (int t = 0; t < 4; t++) cyc(1, mk(10 + t, 3, 0), 0, 0, 0, "R5 hit set3");
    cyc(1, mk(11, 3, 3), 0, 0, 0, "R1 offset ignored");
    cyc(1, mk(11, 4, 0), 0, 0, 0, "R1 other set misses");
    cyc(1, mk(20, 3, 0), 0, 0, 0, "R9 miss");
    cyc(1, mk(20, 3, 1), 0, 0, 0, "R9 victim unchanged after miss");
    cyc(1, mk(10, 3, 0), 1, mk(21, 3, 0), 16'hBEEF, "R7 lookup with fill");
    cyc(1, mk(21, 3, 0), 0, 0, 0, "R7 fill visible");
    cyc(1, mk(13, 3, 0), 0, 0, 0, "R7 recency from fill only");
    cyc(0, mk(21, 3, 0), 1, mk(21, 3, 0), 16'h5A5A, "R3 refill present tag");
    cyc(1, mk(21, 3, 2), 0, 0, 0, "R3 single match after refill");

    for (int i = 0; i < 4000; i++) begin
      bit lv, fv;
      lv = ($urandom % 10) < 8;
      fv = ($urandom % 10) < 3;
      cyc(lv, mk($urandom % 5, $urandom % SETS, $urandom % 4), fv,
          mk($urandom % 5, $urandom % SETS, $urandom % 4), 16'($urandom), "random R4 R5 R6");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule